// File: doc/BRIEF.md
# Sampling Converter Read Sequencer

This block sits on the host side of a parallel-output 12-bit sampling converter and runs it at a fixed sample rate. An internal divider produces a sample tick every `SAMPLE_DIV` system clocks. On each tick the sequencer raises the convert-start line for a programmed number of clocks. It then waits for the converter's active-low busy line to come back high, and after that runs a chip-select/read cycle. Every width and wait in that cycle is counted in system clocks. The converted word is captured at the first clock edge at which the access time has elapsed, and it is presented with a one-cycle valid strobe.

Busy is an asynchronous input and passes through a synchronizer. Busy is not looked at during a blanking window that follows the convert-start pulse, because the converter may take that long to pull busy low. If busy never returns high, a timeout ends the attempt with an error pulse. A tick that lands while an earlier conversion or read is still running is dropped, and an overrun pulse is raised. A sleep request parks the converter in its low-power mode with read held high. Releasing the request restores the mode pin, waits a programmable number of clocks, and then runs one throw-away conversion. That conversion's read is performed but never reported.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While `rst_n` is low, `cnv_start`, `sample_valid`, `overrun` and `timeout_err` are 0, and `cs_n`, `rd_n` and `pwr_mode` are 1.
- R2: Regular (non-throw-away) conversions start only on sample ticks, which occur every `SAMPLE_DIV` clocks. The interval between any two regular `cnv_start` rising edges is therefore a whole multiple of `SAMPLE_DIV`.
- R3: `cnv_start` is high for exactly `CNV_W` consecutive clocks per conversion.
- R4: `busy_n` is ignored for `BLANK_CYC` clocks after `cnv_start` falls. `cs_n` never falls before `busy_n` has returned high for the current conversion.
- R5: `cs_n` and `rd_n` fall together, exactly `SYNC_STAGES + 1` clocks after `busy_n` rises. This assumes the rise occurs once the blanking window is over.
- R6: `rd_n` stays low for exactly `RD_W` clocks, and `cs_n` rises on the same clock as `rd_n`.
- R7: `adc_data` is sampled on the clock edge `ACC_CYC` clocks after `rd_n` falls. `sample_valid` is high for that one following cycle, carrying the sampled word on `sample_data`, and is never high outside a read.
- R8: After `rd_n` rises, `cnv_start` does not rise for at least `RELQ_CYC` clocks.
- R9: If `busy_n` does not rise within `BUSY_TMO` clocks of the end of blanking, `timeout_err` pulses for one cycle. This happens `CNV_W + BLANK_CYC + BUSY_TMO` clocks after `cnv_start` rose. No read is performed and the next tick starts a fresh conversion.
- R10: A tick that arrives while a conversion, read or bus-release wait is in progress pulses `overrun` for one cycle and starts no conversion.
- R11: With `sleep_req` high while idle, `pwr_mode` goes to 0 on the next clock, and `rd_n` and `cs_n` stay 1. No conversion starts and ticks raise no overrun until `sleep_req` falls.
- R12: When `sleep_req` falls, `pwr_mode` returns to 1 on the next clock. A conversion then starts `WAKE_CYC` clocks later, and its read runs with no `sample_valid`. The next conversion reports normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Level request to hold the converter in power save |
| busy_n | input | 1 | Converter busy, low while converting (asynchronous) |
| adc_data | input | DATA_W | Converter parallel data bus |
| cnv_start | output | 1 | Convert-start pulse, rising edge starts conversion |
| cs_n | output | 1 | Converter chip select, active low |
| rd_n | output | 1 | Converter read strobe, active low |
| pwr_mode | output | 1 | Converter mode pin, 0 selects power save |
| sample_data | output | DATA_W | Last captured conversion word |
| sample_valid | output | 1 | One-cycle strobe for a new `sample_data` |
| overrun | output | 1 | One-cycle pulse when a tick is dropped |
| timeout_err | output | 1 | One-cycle pulse when busy never returned |

## Verification
The bench's converter model draws a random busy-fall delay anywhere inside the blanking window. A controller that watched busy too early would read straight away on the stale high level. The model also draws a random conversion length and a random data word. During the read it drives the complement of the word until one clock before the access point, so a capture one edge early returns the wrong value. Fixed words at the all-zero, all-one and mid-scale codes, together with the latest allowed busy fall, cover the extremes. A busy low longer than the tick period separates overrun handling from the start of the next conversion. A busy that never returns exposes the timeout and the recovery that follows. A sleep-and-wake sequence tells the throw-away conversion apart from the regular one after it.

// File: rtl/adc_rd_pkg.sv
// Shared types and helpers for the converter read sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_rd_pkg;

    // Sequencer phases; order carries no meaning.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV,
        ST_BLANK,
        ST_WAITB,
        ST_READ,
        ST_RELQ,
        ST_SLEEP,
        ST_WAKE
    } seq_state_t;

    // Larger of two counts, used to size shared timers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_tick_gen.sv
// Sample-rate divider: pulses tick for one clock every DIV clocks.
// Assumes DIV >= 2; first tick comes DIV-1 clocks after reset release.
module adc_tick_gen #(
    parameter int DIV = 2000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CW'(1);
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/adc_busy_sync.sv
// Brings the asynchronous busy line into the clock domain.
// STAGES = 1 gives a single register; larger values give a shift chain.
// Reset value is 1 (converter idle).
module adc_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_n,
    output logic busy_ok
);
    generate
        if (STAGES < 2) begin : g_one
            logic s_q;
            // Single capture register.
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= 1'b1;
                else        s_q <= busy_n;
            end
            assign busy_ok = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] s_q;
            // Multi-stage shift toward the last bit.
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= '1;
                else        s_q <= {s_q[STAGES-2:0], busy_n};
            end
            assign busy_ok = s_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/adc_seq_fsm.sv
// Conversion and read sequencer. One shared timer counts the clocks spent
// in each phase. Strobes are decoded from the state register; capture,
// valid and flag pulses are registered.
// Assumes: every count >= 1 and ACC_CYC < RD_W.
module adc_seq_fsm
    import adc_rd_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int CNV_W     = 6,
    parameter int BLANK_CYC = 20,
    parameter int BUSY_TMO  = 2000,
    parameter int RD_W      = 15,
    parameter int ACC_CYC   = 14,
    parameter int RELQ_CYC  = 9,
    parameter int WAKE_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              busy_ok,
    input  logic              sleep_req,
    input  logic [DATA_W-1:0] adc_data,
    output logic              cnv_start,
    output logic              cs_n,
    output logic              rd_n,
    output logic              pwr_mode,
    output logic [DATA_W-1:0] sample_data,
    output logic              sample_valid,
    output logic              overrun,
    output logic              timeout_err
);
    localparam int TMAX = imax(imax(imax(CNV_W, BLANK_CYC), imax(BUSY_TMO, RD_W)),
                               imax(RELQ_CYC, WAKE_CYC));
    localparam int TW = $clog2(TMAX + 1);
    localparam logic [TW-1:0] CNV_LAST   = TW'(CNV_W - 1);
    localparam logic [TW-1:0] BLANK_LAST = TW'(BLANK_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST   = TW'(BUSY_TMO - 1);
    localparam logic [TW-1:0] RD_LAST    = TW'(RD_W - 1);
    localparam logic [TW-1:0] ACC_LAST   = TW'(ACC_CYC - 1);
    localparam logic [TW-1:0] RELQ_LAST  = TW'(RELQ_CYC - 1);
    localparam logic [TW-1:0] WAKE_LAST  = TW'(WAKE_CYC - 1);

    seq_state_t        state_q, state_d;
    logic [TW-1:0]     tmr_q, tmr_d;
    logic              dummy_q, dummy_d;
    logic              cap, tmo_hit, in_conv;
    logic [DATA_W-1:0] data_q;
    logic              valid_q, ovr_q, tmo_q;

    // Next phase, timer and throw-away marker.
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q + TW'(1);
        dummy_d = dummy_q;
        cap     = 1'b0;
        tmo_hit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_d = '0;
                if (sleep_req) state_d = ST_SLEEP;
                else if (tick) state_d = ST_CNV;
            end
            ST_CNV: if (tmr_q == CNV_LAST) begin
                state_d = ST_BLANK;
                tmr_d   = '0;
            end
            ST_BLANK: if (tmr_q == BLANK_LAST) begin
                state_d = ST_WAITB;
                tmr_d   = '0;
            end
            ST_WAITB: begin
                if (busy_ok) begin
                    state_d = ST_READ;
                    tmr_d   = '0;
                end else if (tmr_q == TMO_LAST) begin
                    state_d = ST_IDLE;
                    tmr_d   = '0;
                    dummy_d = 1'b0;
                    tmo_hit = 1'b1;
                end
            end
            ST_READ: begin
                if (tmr_q == ACC_LAST) cap = !dummy_q;
                if (tmr_q == RD_LAST) begin
                    state_d = ST_RELQ;
                    tmr_d   = '0;
                end
            end
            ST_RELQ: if (tmr_q == RELQ_LAST) begin
                state_d = ST_IDLE;
                tmr_d   = '0;
                dummy_d = 1'b0;
            end
            ST_SLEEP: begin
                tmr_d = '0;
                if (!sleep_req) state_d = ST_WAKE;
            end
            ST_WAKE: if (tmr_q == WAKE_LAST) begin
                state_d = ST_CNV;
                tmr_d   = '0;
                dummy_d = 1'b1;
            end
            default: begin
                state_d = ST_IDLE;
                tmr_d   = '0;
            end
        endcase
    end

    // State, timer and marker registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            dummy_q <= 1'b0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            dummy_q <= dummy_d;
        end
    end

    assign in_conv = (state_q == ST_CNV) || (state_q == ST_BLANK) ||
                     (state_q == ST_WAITB) || (state_q == ST_READ) ||
                     (state_q == ST_RELQ);

    // Data capture and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            if (cap) data_q <= adc_data;
            valid_q <= cap;
            ovr_q   <= tick && in_conv;
            tmo_q   <= tmo_hit;
        end
    end

    assign cnv_start    = (state_q == ST_CNV);
    assign cs_n         = (state_q != ST_READ);
    assign rd_n         = (state_q != ST_READ);
    assign pwr_mode     = (state_q != ST_SLEEP);
    assign sample_data  = data_q;
    assign sample_valid = valid_q;
    assign overrun      = ovr_q;
    assign timeout_err  = tmo_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
// Top of the converter read sequencer: tick divider, busy synchronizer
// and phase sequencer. All times are in system-clock cycles.
// Assumes: busy_n may change at any time; all outputs are glitch-free
// decodes of registers.
module adc_rd_ctrl #(
    parameter int DATA_W      = 12,
    parameter int SAMPLE_DIV  = 2000,
    parameter int CNV_W       = 6,
    parameter int BLANK_CYC   = 20,
    parameter int BUSY_TMO    = 2000,
    parameter int RD_W        = 15,
    parameter int ACC_CYC     = 14,
    parameter int RELQ_CYC    = 9,
    parameter int WAKE_CYC    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              busy_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              cnv_start,
    output logic              cs_n,
    output logic              rd_n,
    output logic              pwr_mode,
    output logic [DATA_W-1:0] sample_data,
    output logic              sample_valid,
    output logic              overrun,
    output logic              timeout_err
);
    logic tick;
    logic busy_ok;

    adc_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_n  (busy_n),
        .busy_ok (busy_ok)
    );

    adc_seq_fsm #(
        .DATA_W    (DATA_W),
        .CNV_W     (CNV_W),
        .BLANK_CYC (BLANK_CYC),
        .BUSY_TMO  (BUSY_TMO),
        .RD_W      (RD_W),
        .ACC_CYC   (ACC_CYC),
        .RELQ_CYC  (RELQ_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .busy_ok      (busy_ok),
        .sleep_req    (sleep_req),
        .adc_data     (adc_data),
        .cnv_start    (cnv_start),
        .cs_n         (cs_n),
        .rd_n         (rd_n),
        .pwr_mode     (pwr_mode),
        .sample_data  (sample_data),
        .sample_valid (sample_valid),
        .overrun      (overrun),
        .timeout_err  (timeout_err)
    );
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
// Protocol checker for the read sequencer's converter-side pins.
// Pulse widths and gaps are measured with local counters, so no property
// depth depends on a parameter.
module adc_rd_ctrl_chk #(
    parameter int CNV_W    = 6,
    parameter int RD_W     = 15,
    parameter int RELQ_CYC = 9
) (
    input logic clk,
    input logic rst_n,
    input logic cnv_start,
    input logic cs_n,
    input logic rd_n,
    input logic busy_n,
    input logic pwr_mode,
    input logic sample_valid,
    input logic timeout_err
);
    logic [15:0] cnv_run, rd_run, rd_gap;

    // Length of the current high run of cnv_start.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnv_run <= '0;
        else if (cnv_start) cnv_run <= cnv_run + 16'd1;
        else                cnv_run <= '0;
    end

    // Length of the current low run of rd_n.
    always_ff @(posedge clk) begin
        if (!rst_n)  rd_run <= '0;
        else if (!rd_n) rd_run <= rd_run + 16'd1;
        else         rd_run <= '0;
    end

    // Clocks rd_n has been high since its last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               rd_gap <= 16'hFFFF;
        else if (!rd_n)           rd_gap <= '0;
        else if (rd_gap != 16'hFFFF) rd_gap <= rd_gap + 16'd1;
    end

    // R3
    cnv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_start) |-> (cnv_run == 16'(CNV_W)));

    // R6
    rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (rd_run == 16'(RD_W)));

    // R4
    cs_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> busy_n);

    // R7
    valid_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> !rd_n);

    // R8
    relq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_start) |-> (rd_gap >= 16'(RELQ_CYC)));

    // R11
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_mode |-> (rd_n && cs_n && !cnv_start));

    // R9
    tmo_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (rd_n && cs_n && !sample_valid));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .CNV_W    (CNV_W),
    .RD_W     (RD_W),
    .RELQ_CYC (RELQ_CYC)
) u_adc_rd_ctrl_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnv_start    (cnv_start),
    .cs_n         (cs_n),
    .rd_n         (rd_n),
    .busy_n       (busy_n),
    .pwr_mode     (pwr_mode),
    .sample_valid (sample_valid),
    .timeout_err  (timeout_err)
);

// File: tb/adc_rd_ctrl_bench.sv
// Bench: behavioural converter model plus seeded random and directed runs.
module adc_rd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 12;
    localparam int DIV   = 200;
    localparam int CNVW  = 6;
    localparam int BLANK = 20;
    localparam int TMO   = 300;
    localparam int RDW   = 15;
    localparam int ACC   = 14;
    localparam int RELQ  = 9;
    localparam int WAKE  = 1;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic busy_n = 1'b1;
    logic [DW-1:0] adc_data = '0;
    logic cnv_start, cs_n, rd_n, pwr_mode, sample_valid, overrun, timeout_err;
    logic [DW-1:0] sample_data;

    adc_rd_ctrl #(
        .DATA_W(DW), .SAMPLE_DIV(DIV), .CNV_W(CNVW), .BLANK_CYC(BLANK),
        .BUSY_TMO(TMO), .RD_W(RDW), .ACC_CYC(ACC), .RELQ_CYC(RELQ),
        .WAKE_CYC(WAKE), .SYNC_STAGES(SYNC)
    ) u_adc_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .busy_n(busy_n),
        .adc_data(adc_data), .cnv_start(cnv_start), .cs_n(cs_n), .rd_n(rd_n),
        .pwr_mode(pwr_mode), .sample_data(sample_data),
        .sample_valid(sample_valid), .overrun(overrun),
        .timeout_err(timeout_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Expected timing, from the requirements.
    function automatic int exp_read_lag();
        return SYNC + 1;
    endfunction
    function automatic int exp_tmo_lag();
        return CNVW + BLANK + TMO;
    endfunction
    function automatic int exp_valids(input bit throwaway);
        return throwaway ? 0 : 1;
    endfunction

    // Plan for the next conversion, set by the stimulus process.
    int plan_len = 30;
    int plan_drop = 3;
    logic [DW-1:0] plan_word = '0;
    int wake_req_n = 0;

    // Model and monitor state.
    int cyc = 0, phase = 0, k = 0, cnv_hi = 0, rk = 0, vcount = 0;
    int cur_len = 0, cur_drop = 0, t_busy_rise = 0, t_cnv = 0, t_tmo = 0;
    int prev_reg = -1, t_rd_rise = -1000, wake_seen = 0;
    int conv_n = 0, reads_done = 0, ovr_cnt = 0, tmo_cnt = 0, sleep_viol = 0;
    logic [DW-1:0] cur_word = '0;
    bit cur_dummy = 1'b0, in_read = 1'b0;
    bit cnv_p = 1'b0, cs_p = 1'b1, rd_p = 1'b1;

    // Converter model and pin monitor, all at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (overrun) ovr_cnt++;
            if (timeout_err) begin tmo_cnt++; t_tmo = cyc; end
            if (!pwr_mode && (cnv_start || !rd_n || !cs_n)) sleep_viol++;
            if (cnv_start && !cnv_p) begin
                conv_n++;
                t_cnv = cyc;
                cur_dummy = (wake_req_n != wake_seen);
                wake_seen = wake_req_n;
                if (!cur_dummy) begin
                    if (prev_reg >= 0)
                        check(((cyc - prev_reg) % DIV) == 0, "R2", "start spacing mod DIV",
                              (cyc - prev_reg) % DIV, 0);
                    prev_reg = cyc;
                end
                check(cyc - t_rd_rise >= RELQ, "R8", "gap after read", cyc - t_rd_rise, RELQ);
                cur_len = plan_len; cur_drop = plan_drop; cur_word = plan_word;
                phase = 1; k = 0; cnv_hi = 0;
            end
            if (cnv_start) cnv_hi++;
            if (!cnv_start && cnv_p) check(cnv_hi == CNVW, "R3", "convert width", cnv_hi, CNVW);
            if (phase == 1) begin
                k++;
                if (k >= cur_drop) begin busy_n = 1'b0; phase = 2; k = 0; end
            end else if (phase == 2) begin
                k++;
                if (k >= cur_len) begin busy_n = 1'b1; phase = 3; t_busy_rise = cyc; end
            end
            if (!cs_n && cs_p) begin
                check(phase == 3, "R4", "select before busy release", phase, 3);
                check(cyc - t_busy_rise == exp_read_lag(), "R5", "select lag",
                      cyc - t_busy_rise, exp_read_lag());
                check(!rd_n, "R5", "read with select", int'(rd_n), 0);
                in_read = 1'b1; rk = 0; vcount = 0;
            end else if (in_read && !rd_n) begin
                rk++;
            end
            if (sample_valid) begin
                if (!in_read || rd_n) begin
                    check(1'b0, "R7", "valid outside read", 1, 0);
                end else begin
                    vcount++;
                    check(rk == ACC, "R7", "capture cycle", rk, ACC);
                    check(sample_data == cur_word, "R7", "captured word",
                          int'(sample_data), int'(cur_word));
                end
            end
            if (in_read && rd_n && !rd_p) begin
                in_read = 1'b0;
                check(rk + 1 == RDW, "R6", "read width", rk + 1, RDW);
                check(cs_n, "R6", "select release", int'(cs_n), 1);
                check(vcount == exp_valids(cur_dummy), cur_dummy ? "R12" : "R7",
                      "valid count", vcount, exp_valids(cur_dummy));
                reads_done++;
                t_rd_rise = cyc;
            end
            if (in_read && !rd_n) adc_data = (rk >= ACC - 1) ? cur_word : ~cur_word;
            else                  adc_data = ~cur_word;
            cnv_p = cnv_start; cs_p = cs_n; rd_p = rd_n;
        end
    end

    task automatic run_conv(input int len, input int drop, input logic [DW-1:0] w);
        int tgt;
        plan_len = len; plan_drop = drop; plan_word = w;
        tgt = reads_done + 1;
        while (reads_done < tgt) @(negedge clk);
    endtask

    task automatic random_convs(input int n);
        for (int i = 0; i < n; i++)
            run_conv(int'($urandom_range(60, 30)), int'($urandom_range(CNVW + BLANK - 1, 1)),
                     DW'($urandom));
    endtask

    initial begin
        int seed, o0, r0, c0, tstart, v0;
        seed = int'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!cnv_start, "R1", "cnv_start in reset", int'(cnv_start), 0);
        check(cs_n && rd_n, "R1", "cs_n/rd_n in reset", int'(cs_n & rd_n), 1);
        check(pwr_mode, "R1", "pwr_mode in reset", int'(pwr_mode), 1);
        check(!sample_valid && !overrun && !timeout_err, "R1", "pulses in reset",
              int'(sample_valid | overrun | timeout_err), 0);
        rst_n = 1'b1;

        random_convs(20);
        // Boundary words with the latest busy fall inside blanking (R4, R7)
        run_conv(30, CNVW + BLANK - 1, 12'h000);
        run_conv(30, CNVW + BLANK - 1, 12'hFFF);
        run_conv(30, CNVW + BLANK - 1, 12'h800);
        run_conv(30, CNVW + BLANK - 1, 12'h7FF);

        // R10: a tick during a long conversion is dropped
        o0 = ovr_cnt; c0 = conv_n;
        run_conv(250, 3, 12'h3C5);
        check(ovr_cnt - o0 == 1, "R10", "overrun pulses", ovr_cnt - o0, 1);
        run_conv(30, 3, 12'h5A5);
        check(conv_n - c0 == 2, "R10", "conversions after drop", conv_n - c0, 2);

        // R9: busy never returns
        o0 = ovr_cnt; r0 = reads_done; c0 = conv_n; v0 = tmo_cnt;
        plan_len = 1000; plan_drop = 3; plan_word = 12'h111;
        while (conv_n == c0) @(negedge clk);
        tstart = t_cnv;
        plan_len = 30; plan_drop = 3; plan_word = 12'h9E1;
        while (tmo_cnt == v0) @(negedge clk);
        check(t_tmo - tstart == exp_tmo_lag(), "R9", "timeout cycle", t_tmo - tstart, exp_tmo_lag());
        check(reads_done == r0, "R9", "reads during timeout", reads_done - r0, 0);
        check(ovr_cnt - o0 == 1, "R10", "overrun during wait", ovr_cnt - o0, 1);
        while (reads_done == r0) @(negedge clk);
        check(conv_n - c0 == 2, "R9", "fresh conversion after timeout", conv_n - c0, 2);

        // R11: power save
        repeat (12) @(negedge clk);
        o0 = ovr_cnt; c0 = conv_n; v0 = sleep_viol;
        sleep_req = 1'b1;
        @(negedge clk);
        check(!pwr_mode, "R11", "mode low", int'(pwr_mode), 0);
        check(rd_n && cs_n, "R11", "read held high", int'(rd_n & cs_n), 1);
        repeat (650) @(negedge clk);
        check(conv_n == c0, "R11", "conversions while asleep", conv_n - c0, 0);
        check(ovr_cnt == o0, "R11", "overruns while asleep", ovr_cnt - o0, 0);
        check(sleep_viol == v0, "R11", "pin activity while asleep", sleep_viol - v0, 0);

        // R12: wake, throw-away conversion, then a normal one
        plan_len = 30; plan_drop = 3; plan_word = 12'h123;
        r0 = reads_done;
        wake_req_n++;
        sleep_req = 1'b0;
        @(negedge clk);
        check(pwr_mode, "R12", "mode restored", int'(pwr_mode), 1);
        repeat (WAKE) @(negedge clk);
        check(cnv_start, "R12", "throw-away start", int'(cnv_start), 1);
        while (reads_done == r0) @(negedge clk);
        run_conv(35, 4, 12'hABC);

        random_convs(10);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            finish_run();
        end
    end
endmodule